// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block decides, in a single combinational step, whether the decode stage of a five-stage RV32I pipeline may advance this cycle. It decodes the 32-bit instruction sitting in decode to learn which source registers that instruction truly reads. It then compares those sources against the destination registers of the instructions in the execute and memory stages. It drives four controls: a hold for the program counter, a hold for the fetch/decode register, a bubble into execute, and a flush for the fetch slot.

A register-number match alone does not raise a hazard. The match counts only when the decoded opcode shows that the source field really names a register. LUI and AUIPC reuse that field for immediate bits, JAL does the same, and the immediate CSR forms put a 5-bit constant there. Branches and JALR are resolved in decode, so they also wait for a plain ALU result still in execute, and for a load result still in memory.

Top module: `hazard_unit`

## Requirements
- R1: The second source (instr[24:20]) is treated as read only for opcode 0110011 (register-register), 0100011 (store) and 1100011 (branch). For any other opcode a match on that field never causes a stall.
- R2: The first source (instr[19:15]) is treated as not read for opcode 1101111 (JAL), 0110111 (LUI), 0010111 (AUIPC), 0001111 (FENCE), and for opcode 1110011 with funct3 (instr[14:12]) of 101, 110 or 111. It is treated as read for every other opcode.
- R3: When the execute stage holds a load (ex_is_load=1, ex_wr_en=1) whose destination equals a source that the decode instruction reads, pc_hold, fd_hold and ex_bubble are all 1.
- R4: A producer whose destination is register 0, or whose write enable is 0, never causes a stall.
- R5: A decode instruction with opcode 1100011 (branch) or 1100111 (JALR) stalls when the execute stage writes a register it reads, whether or not that producer is a load.
- R6: A branch or JALR in decode stalls when the memory stage holds a load that writes a register it reads. A non-load in memory causes no stall.
- R7: A decode instruction that is neither a branch nor JALR never stalls on the memory stage, and does not stall on a non-load in execute.
- R8: fetch_flush is 1 exactly when id_jump_taken is 1 and no stall is raised.
- R9: While a stall is raised, fetch_flush is 0 even when id_jump_taken is 1.
- R10: pc_hold, fd_hold and ex_bubble always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in the decode stage |
| id_jump_taken | input | 1 | Decode has resolved a taken branch or jump |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| pc_hold | output | 1 | Keep the program counter, fetch nothing new |
| fd_hold | output | 1 | Keep the fetch/decode pipeline register |
| ex_bubble | output | 1 | Load a no-op into execute (decode flushed forward) |
| fetch_flush | output | 1 | Discard the instruction in the fetch slot |

## Verification
The hardest case to reach is a redirect that must be held back. A taken branch or JALR in decode has to meet a load in memory, or any register write in execute, that targets the register the jump reads. In that case the flush must stay low while the three holds rise. The bench builds these cases on purpose with encoded JALR and branch words against chosen stage destinations. It adds look-alike cases where the matching field is really immediate bits (LUI, JAL, CSRRWI, AUIPC). It then runs a long random phase that draws register numbers from a tiny pool, so that field collisions in every opcode class are frequent. Each cycle is compared against a behavioural model.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned RF_AW  = 5;
  localparam int unsigned OPC_W  = 7;

  localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

  // funct3 values of the CSR forms carrying a 5-bit constant
  localparam logic [2:0] F3_CSR_IMM_W = 3'b101;
  localparam logic [2:0] F3_CSR_IMM_S = 3'b110;
  localparam logic [2:0] F3_CSR_IMM_C = 3'b111;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_A   = 0;
  localparam int unsigned SRC_B   = 1;

  // producer slots, ordered from youngest to oldest
  localparam int unsigned NUM_PROD = 2;
  localparam int unsigned PROD_EX  = 0;
  localparam int unsigned PROD_MEM = 1;

  typedef struct packed {
    logic [RF_AW-1:0] idx;
    logic             used;
  } src_t;

  typedef struct packed {
    logic [RF_AW-1:0] rd;
    logic             wr_en;
    logic             is_load;
  } prod_t;

endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import hazard_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output src_t              src [NUM_SRC],
  output logic              resolves_in_id
);

  logic [OPC_W-1:0] opc;
  logic [2:0]       f3;
  logic             csr_imm_form;
  logic             a_field_is_imm;
  logic             b_field_is_reg;
  logic             unused_fields;

  assign opc           = instr[6:0];
  assign f3            = instr[14:12];
  assign unused_fields = ^{instr[31:25], instr[11:7]};

  always_comb begin
    csr_imm_form = 1'b0;
    if (opc == OPC_SYSTEM) begin
      unique case (f3)
        F3_CSR_IMM_W, F3_CSR_IMM_S, F3_CSR_IMM_C: csr_imm_form = 1'b1;
        default:                                  csr_imm_form = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (opc)
      OPC_JAL, OPC_LUI, OPC_AUIPC, OPC_FENCE: a_field_is_imm = 1'b1;
      default:                                a_field_is_imm = csr_imm_form;
    endcase
  end

  always_comb begin
    unique case (opc)
      OPC_REGREG, OPC_STORE, OPC_BRANCH: b_field_is_reg = 1'b1;
      default:                           b_field_is_reg = 1'b0;
    endcase
  end

  always_comb begin
    src[SRC_A].idx  = instr[19:15];
    src[SRC_A].used = ~a_field_is_imm;
    src[SRC_B].idx  = instr[24:20];
    src[SRC_B].used = b_field_is_reg;
  end

  assign resolves_in_id = (opc == OPC_BRANCH) || (opc == OPC_JALR);

endmodule

// File: rtl/hz_dep_match.sv
module hz_dep_match
  import hazard_pkg::*;
(
  input  src_t  src [NUM_SRC],
  input  prod_t prod,
  output logic  hit
);

  logic prod_live;
  logic [NUM_SRC-1:0] src_hit;

  assign prod_live = prod.wr_en && (prod.rd != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_hit[s] = src[s].used && (src[s].idx == prod.rd);
  end

  assign hit = prod_live && (|src_hit);

endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hazard_pkg::*;
(
  input  logic [NUM_PROD-1:0] hit,
  input  logic [NUM_PROD-1:0] load,
  input  logic                resolves_in_id,
  input  logic                jump_taken,
  output logic                stall,
  output logic                redirect_flush
);

  logic load_use;
  logic early_need;

  assign load_use = hit[PROD_EX] && load[PROD_EX];

  // a jump read in decode needs the youngest result, and any older load
  always_comb begin
    early_need = 1'b0;
    for (int p = 0; p < NUM_PROD; p++) begin
      if (p == PROD_EX) early_need = early_need | hit[p];
      else              early_need = early_need | (hit[p] & load[p]);
    end
  end

  assign stall          = load_use || (resolves_in_id && early_need);
  assign redirect_flush = jump_taken && !stall;

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic [31:0] id_instr,
  input  logic        id_jump_taken,
  input  logic [4:0]  ex_rd,
  input  logic        ex_wr_en,
  input  logic        ex_is_load,
  input  logic [4:0]  mem_rd,
  input  logic        mem_wr_en,
  input  logic        mem_is_load,
  output logic        pc_hold,
  output logic        fd_hold,
  output logic        ex_bubble,
  output logic        fetch_flush
);

  src_t               src [NUM_SRC];
  prod_t              prod [NUM_PROD];
  logic [NUM_PROD-1:0] hit;
  logic [NUM_PROD-1:0] load;
  logic               resolves_in_id;
  logic               stall;

  always_comb begin
    prod[PROD_EX]  = '{rd: ex_rd,  wr_en: ex_wr_en,  is_load: ex_is_load};
    prod[PROD_MEM] = '{rd: mem_rd, wr_en: mem_wr_en, is_load: mem_is_load};
  end

  hz_src_decode u_dec (
    .instr          (id_instr),
    .src            (src),
    .resolves_in_id (resolves_in_id)
  );

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    hz_dep_match u_match (
      .src  (src),
      .prod (prod[p]),
      .hit  (hit[p])
    );
    assign load[p] = prod[p].is_load;
  end

  hz_arbiter u_arb (
    .hit            (hit),
    .load           (load),
    .resolves_in_id (resolves_in_id),
    .jump_taken     (id_jump_taken),
    .stall          (stall),
    .redirect_flush (fetch_flush)
  );

  assign pc_hold   = stall;
  assign fd_hold   = stall;
  assign ex_bubble = stall;

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk (
  input logic [31:0] id_instr,
  input logic        id_jump_taken,
  input logic [4:0]  ex_rd,
  input logic        ex_wr_en,
  input logic        ex_is_load,
  input logic [4:0]  mem_rd,
  input logic        mem_wr_en,
  input logic        mem_is_load,
  input logic        pc_hold,
  input logic        fd_hold,
  input logic        ex_bubble,
  input logic        fetch_flush
);

  logic known;
  assign known = !$isunknown({id_instr, id_jump_taken, ex_rd, ex_wr_en, ex_is_load,
                              mem_rd, mem_wr_en, mem_is_load,
                              pc_hold, fd_hold, ex_bubble, fetch_flush});

  always_comb begin
    if (known) begin
      AST_HOLDS_AGREE: assert ((pc_hold == fd_hold) && (fd_hold == ex_bubble))
        else $error("holds disagree"); // R10
      AST_FLUSH_BLOCKED: assert (!(pc_hold && fetch_flush))
        else $error("flush during stall"); // R9
      AST_FLUSH_NEEDS_JUMP: assert (!fetch_flush || id_jump_taken)
        else $error("flush without jump"); // R8
      AST_FLUSH_ON_FREE_JUMP: assert (!(id_jump_taken && !pc_hold) || fetch_flush)
        else $error("free jump not flushed"); // R8
      AST_X0_QUIET: assert (!((ex_rd == 5'd0) && (mem_rd == 5'd0) && pc_hold))
        else $error("stall on x0"); // R4
      AST_NO_WRITER_QUIET: assert (!(!ex_wr_en && !mem_wr_en && pc_hold))
        else $error("stall without writer"); // R4
      AST_LUI_QUIET: assert (!((id_instr[6:0] == 7'b0110111) && pc_hold))
        else $error("LUI stalled"); // R2
      AST_LOAD_USE: assert (!(ex_is_load && ex_wr_en && (ex_rd != 5'd0) &&
                              (id_instr[6:0] == 7'b0110011) &&
                              (id_instr[19:15] == ex_rd)) || pc_hold)
        else $error("load-use missed"); // R3
    end
  end

endmodule

bind hazard_unit hazard_unit_chk u_chk (
  .id_instr      (id_instr),
  .id_jump_taken (id_jump_taken),
  .ex_rd         (ex_rd),
  .ex_wr_en      (ex_wr_en),
  .ex_is_load    (ex_is_load),
  .mem_rd        (mem_rd),
  .mem_wr_en     (mem_wr_en),
  .mem_is_load   (mem_is_load),
  .pc_hold       (pc_hold),
  .fd_hold       (fd_hold),
  .ex_bubble     (ex_bubble),
  .fetch_flush   (fetch_flush)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] id_instr;
  logic        id_jump_taken;
  logic [4:0]  ex_rd, mem_rd;
  logic        ex_wr_en, ex_is_load, mem_wr_en, mem_is_load;
  logic        pc_hold, fd_hold, ex_bubble, fetch_flush;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  hazard_unit uut (
    .id_instr(id_instr), .id_jump_taken(id_jump_taken),
    .ex_rd(ex_rd), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
    .pc_hold(pc_hold), .fd_hold(fd_hold), .ex_bubble(ex_bubble),
    .fetch_flush(fetch_flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] enc(input logic [6:0] opc, input logic [2:0] f3,
                                      input int rs1, input int rs2, input int rd);
    return {7'd0, rs2[4:0], rs1[4:0], f3, rd[4:0], opc};
  endfunction

  // behavioural model: returns {stall, flush}
  function automatic logic [1:0] model(input logic [31:0] i, input logic jt,
                                       input logic [4:0] erd, input logic ewe, input logic eld,
                                       input logic [4:0] mrd, input logic mwe, input logic mld);
    int op = i[6:0];
    int f3 = i[14:12];
    int a = i[19:15];
    int b = i[24:20];
    bit ua, ub, ctl, he, hm, st;
    ub = (op == 'h33) || (op == 'h23) || (op == 'h63);
    ua = 1;
    if (op == 'h6f || op == 'h37 || op == 'h17 || op == 'h0f) ua = 0;
    if (op == 'h73 && f3 >= 5) ua = 0;
    ctl = (op == 'h63) || (op == 'h67);
    he = ewe && erd != 0 && ((ua && a == erd) || (ub && b == erd));
    hm = mwe && mrd != 0 && ((ua && a == mrd) || (ub && b == mrd));
    st = (eld && he) || (ctl && (he || (mld && hm)));
    return {st, jt && !st};
  endfunction

  task automatic drive(input logic [31:0] i, input logic jt,
                       input logic [4:0] erd, input logic ewe, input logic eld,
                       input logic [4:0] mrd, input logic mwe, input logic mld);
    @(posedge clk);
    id_instr = i; id_jump_taken = jt;
    ex_rd = erd; ex_wr_en = ewe; ex_is_load = eld;
    mem_rd = mrd; mem_wr_en = mwe; mem_is_load = mld;
  endtask

  task automatic compare(input string tag, input logic exp_st, input logic exp_fl);
    @(negedge clk);
    n_cmp++;
    if ({pc_hold, fd_hold, ex_bubble, fetch_flush} !== {exp_st, exp_st, exp_st, exp_fl}) begin
      n_bad++;
      $display("FAIL %s: got hold=%b%b%b flush=%b, expected hold=%b flush=%b",
               tag, pc_hold, fd_hold, ex_bubble, fetch_flush, exp_st, exp_fl);
    end
  endtask

  task automatic step(input string tag, input logic [31:0] i, input logic jt,
                      input logic [4:0] erd, input logic ewe, input logic eld,
                      input logic [4:0] mrd, input logic mwe, input logic mld);
    logic [1:0] e;
    drive(i, jt, erd, ewe, eld, mrd, mwe, mld);
    e = model(i, jt, erd, ewe, eld, mrd, mwe, mld);
    compare(tag, e[1], e[0]);
  endtask

  task automatic step_exp(input string tag, input logic exp_st, input logic exp_fl,
                          input logic [31:0] i, input logic jt,
                          input logic [4:0] erd, input logic ewe, input logic eld,
                          input logic [4:0] mrd, input logic mwe, input logic mld);
    drive(i, jt, erd, ewe, eld, mrd, mwe, mld);
    compare(tag, exp_st, exp_fl);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    id_instr = 32'h0000_0013; id_jump_taken = 0;
    ex_rd = 0; ex_wr_en = 0; ex_is_load = 0;
    mem_rd = 0; mem_wr_en = 0; mem_is_load = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    compare("R4 idle", 0, 0);

    // R3 load-use through rs1 and through a store's rs2
    step_exp("R3 load-use add", 1, 0, enc(7'h33, 3'd0, 5, 6, 1), 0, 5, 1, 1, 0, 0, 0);
    step_exp("R1 store rs2 after load", 1, 0, enc(7'h23, 3'd2, 7, 9, 0), 0, 9, 1, 1, 0, 0, 0);
    // R1 I-type addi with matching rs2 field
    step_exp("R1 addi rs2 field", 0, 0, enc(7'h13, 3'd0, 3, 9, 4), 0, 9, 1, 1, 0, 0, 0);
    // R2 immediate-field look-alikes
    step_exp("R2 jal rs1 field", 0, 1, enc(7'h6f, 3'd0, 5, 0, 1), 1, 5, 1, 1, 5, 1, 1);
    step_exp("R2 lui rs1 field", 0, 0, enc(7'h37, 3'd0, 5, 0, 2), 0, 5, 1, 1, 0, 0, 0);
    step_exp("R2 auipc rs1 field", 0, 0, enc(7'h17, 3'd0, 8, 0, 2), 0, 8, 1, 1, 0, 0, 0);
    step_exp("R2 csrrwi imm", 0, 0, enc(7'h73, 3'd5, 12, 0, 3), 0, 12, 1, 1, 0, 0, 0);
    step_exp("R2 csrrci imm", 0, 0, enc(7'h73, 3'd7, 12, 0, 3), 0, 12, 1, 1, 0, 0, 0);
    step_exp("R2 fence", 0, 0, enc(7'h0f, 3'd0, 12, 0, 0), 0, 12, 1, 1, 0, 0, 0);
    step_exp("R2 csrrw reads rs1", 1, 0, enc(7'h73, 3'd1, 12, 0, 3), 0, 12, 1, 1, 0, 0, 0);
    // R4 x0 and disabled writers
    step_exp("R4 x0 load", 0, 0, enc(7'h33, 3'd0, 0, 0, 1), 0, 0, 1, 1, 0, 1, 1);
    step_exp("R4 we low", 0, 0, enc(7'h33, 3'd0, 5, 6, 1), 0, 5, 0, 1, 0, 0, 0);
    step_exp("R4 jalr mem we low", 0, 1, enc(7'h67, 3'd0, 10, 0, 1), 1, 0, 0, 0, 10, 0, 1);
    // R5 jump in decode against ALU result in EX
    step_exp("R5 beq on ex alu", 1, 0, enc(7'h63, 3'd0, 3, 4, 0), 1, 4, 1, 0, 0, 0, 0);
    step_exp("R5 jalr on ex alu", 1, 0, enc(7'h67, 3'd0, 6, 0, 1), 1, 6, 1, 0, 0, 0, 0);
    // R6 jump against MEM
    step_exp("R6 jalr load in mem", 1, 0, enc(7'h67, 3'd0, 10, 0, 1), 1, 0, 0, 0, 10, 1, 1);
    step_exp("R6 bne alu in mem", 0, 1, enc(7'h63, 3'd1, 10, 11, 0), 1, 0, 0, 0, 11, 1, 0);
    // R7 ordinary instructions
    step_exp("R7 add load in mem", 0, 0, enc(7'h33, 3'd0, 10, 11, 1), 0, 0, 0, 0, 10, 1, 1);
    step_exp("R7 add alu in ex", 0, 0, enc(7'h33, 3'd0, 10, 11, 1), 0, 11, 1, 0, 0, 0, 0);
    // R8 / R9 flush behaviour
    step_exp("R8 free branch", 0, 1, enc(7'h63, 3'd0, 1, 2, 0), 1, 3, 1, 1, 4, 1, 1);
    step_exp("R8 no jump", 0, 0, enc(7'h63, 3'd0, 1, 2, 0), 0, 3, 1, 1, 4, 1, 1);
    step_exp("R9 stall beats flush", 1, 0, enc(7'h63, 3'd0, 1, 2, 0), 1, 2, 1, 1, 0, 0, 0);

    // R10 and all rules: random mix with colliding register numbers
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] ops [12] = '{7'h33, 7'h23, 7'h63, 7'h6f, 7'h67, 7'h37,
                               7'h17, 7'h0f, 7'h73, 7'h13, 7'h03, 7'h73};
      logic [31:0] w;
      w = $urandom;
      w[6:0]   = ops[$urandom_range(0, 11)];
      w[19:15] = 5'($urandom_range(0, 3));
      w[24:20] = 5'($urandom_range(0, 3));
      step("R10 random", w, 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom),
           1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule